// File: doc/BRIEF.md
# Ramped Soft Mute Controller

This block sits at the end of a stereo sample path and scales both channels by a shared gain that moves by one step per output frame. A mute request walks the gain down from unity to silence over 1024 frames; dropping the request walks it back up at the same rate from wherever it currently stands, so a request withdrawn part-way simply reverses the ramp.

The gain is an 11-bit count from 0 to 1024. Each output sample is the input sample times the count divided by 1024, truncated toward zero, and it is registered once. An optional semi-automatic start keeps the output silent for 4410 frames after reset and then fades in without help, unless the mute request is still held. Reset (active low, synchronous) also acts as power-down and forces both outputs to zero.

Top module: `soft_mute_ramp`

## Requirements
- R1: While `rst_n` is low, both sample outputs are zero one clock later. The gain resets to 1024 when `semi_auto` is 0 (manual) and to 0 when `semi_auto` is 1 (semi-automatic).
- R2: With the mute request in force, every `frame_stb` cycle lowers the gain by one. From 1024 it reaches 0 after exactly 1024 strobes and then stays at 0.
- R3: With no mute in force, every `frame_stb` cycle raises the gain by one until it reaches 1024, where it stays.
- R4: Withdrawing the mute request before the gain reaches 0 turns the ramp around from its current value. Unity is reached after as many strobes as the descent took.
- R5: The gain changes only in cycles where `frame_stb` is high.
- R6: Each output equals its channel input times the gain before that clock edge, divided by 1024 and truncated toward zero. It appears one clock later and is exact at the extremes of the 24-bit two's complement range.
- R7: In semi-automatic mode the gain stays 0 for the first 4410 strobes after reset. It becomes 1 on strobe 4411 and reaches 1024 on strobe 5434, provided `mute_req` stays low.
- R8: In semi-automatic mode, a mute request that is high when reset is released keeps the gain at 0 beyond the hold period. The fade-in starts only on the first strobe after the request drops. The gain never rises while `mute_req` is high.
- R9: `semi_auto` is sampled only while `rst_n` is low. Changing it during operation neither starts a hold nor alters the gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset / power-down |
| frame_stb | input | 1 | One-cycle strobe per output frame; advances the gain |
| mute_req | input | 1 | 1 requests mute |
| semi_auto | input | 1 | 1 selects semi-automatic start; sampled during reset |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| out_left | output | 24 | Scaled left sample, registered |
| out_right | output | 24 | Scaled right sample, registered |
| gain_level | output | 11 | Current gain count, 0..1024 |

## Verification
Full descents and ascents sweep every gain value from 0 to 1024. Along the way, each channel is fed a rotating mix of the largest positive value, the most negative value, −1, +1 and hashed values. This separates truncation toward zero from floor rounding, and it shows sign or overflow mistakes at the range ends. Mid-ramp reversals, sparse strobes and a mode change during operation show whether the counter reverses from its current point, whether it moves only on strobes, and whether the mode is latched only in reset. Two semi-automatic starts, one with the request low and one with it high, pin down the 4410-frame hold boundary and the blocked release.

// File: rtl/smr_pkg.sv
// Shared types for the ramped soft mute controller.
package smr_pkg;
    // Start-up behaviour latched during reset
    typedef enum logic {
        MODE_MANUAL = 1'b0,
        MODE_SEMI   = 1'b1
    } mute_mode_e;

    // Per-strobe action of the gain counter
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_DOWN = 2'd1,
        STEP_UP   = 2'd2
    } gain_step_e;
endpackage

// File: rtl/smr_hold_timer.sv
// Semi-automatic start hold.
// Latches the start mode while reset is low. In semi-automatic mode it counts
// frame strobes after reset and asserts hold_o until HOLD_FRAMES strobes have
// passed. Assumes frame_stb is a single-cycle pulse per frame.
module smr_hold_timer
    import smr_pkg::*;
#(
    parameter int HOLD_FRAMES = 4410
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic semi_req,
    output logic hold_o
);
    localparam int CNT_W = $clog2(HOLD_FRAMES + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(HOLD_FRAMES);

    mute_mode_e       mode_q;
    logic [CNT_W-1:0] cnt_q;

    // Mode is captured only while reset is asserted
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= semi_req ? MODE_SEMI : MODE_MANUAL;
    end

    // Frame count since reset, saturating at the hold length
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (frame_stb && mode_q == MODE_SEMI && cnt_q != CNT_END)
            cnt_q <= cnt_q + 1'b1;
    end

    // Hold is active in semi-automatic mode until the count saturates
    always_comb hold_o = (mode_q == MODE_SEMI) && (cnt_q != CNT_END);

    p_hold_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb && hold_o |=> cnt_q == $past(cnt_q) + 1'b1);

    p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/smr_gain_ramp.sv
// Linear gain ramp counter.
// Holds a gain from 0 to RAMP_LEN and moves it by one per frame strobe:
// down while mute_i is high, up while it is low, saturating at both ends.
// Reset value is unity in manual mode and zero in semi-automatic mode.
// Assumes RAMP_LEN is a power of two.
module smr_gain_ramp
    import smr_pkg::*;
#(
    parameter  int RAMP_LEN = 1024,
    localparam int GAIN_W   = $clog2(RAMP_LEN) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              mute_i,
    input  logic              semi_req,
    output logic [GAIN_W-1:0] gain_o
);
    localparam logic [GAIN_W-1:0] FULL = GAIN_W'(RAMP_LEN);

    logic [GAIN_W-1:0] gain_q;
    gain_step_e        step;

    // Decide the action for this cycle
    always_comb begin
        step = STEP_HOLD;
        if (frame_stb) begin
            if (mute_i && gain_q != '0)
                step = STEP_DOWN;
            else if (!mute_i && gain_q != FULL)
                step = STEP_UP;
        end
    end

    // Gain register with mode-dependent reset value
    always_ff @(posedge clk) begin
        if (!rst_n)
            gain_q <= semi_req ? '0 : FULL;
        else begin
            case (step)
                STEP_DOWN: gain_q <= gain_q - 1'b1;
                STEP_UP:   gain_q <= gain_q + 1'b1;
                default:   gain_q <= gain_q;
            endcase
        end
    end

    always_comb gain_o = gain_q;

    p_gain_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gain_q <= FULL);

    p_fall_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb && mute_i && gain_q != '0 |=> gain_q == $past(gain_q) - 1'b1);

    p_rise_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb && !mute_i && gain_q != FULL |=> gain_q == $past(gain_q) + 1'b1);

    p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> $stable(gain_q));
endmodule

// File: rtl/smr_scaler.sv
// One-channel sample scaler.
// Multiplies a signed sample by an unsigned gain, divides by 2**SHIFT with
// truncation toward zero and registers the result. Output is zero after a
// reset cycle. Assumes gain_i never exceeds 2**SHIFT.
module smr_scaler #(
    parameter int DATA_W = 24,
    parameter int GAIN_W = 11,
    parameter int SHIFT  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] sample_i,
    input  logic        [GAIN_W-1:0] gain_i,
    output logic signed [DATA_W-1:0] sample_o
);
    localparam int PROD_W = DATA_W + GAIN_W + 1;
    localparam logic signed [PROD_W-1:0] BIAS = PROD_W'((1 << SHIFT) - 1);
    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << SHIFT);

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] sum;
    logic signed [DATA_W-1:0] out_d;

    // Product, bias for negative values, arithmetic shift
    always_comb begin
        prod  = PROD_W'(sample_i) * PROD_W'($signed({1'b0, gain_i}));
        sum   = prod + (prod[PROD_W-1] ? BIAS : '0);
        out_d = DATA_W'(sum >>> SHIFT);
    end

    // Output register, cleared in reset
    always_ff @(posedge clk) begin
        if (!rst_n) sample_o <= '0;
        else        sample_o <= out_d;
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> sample_o == '0);

    p_unity_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gain_i == UNITY |=> sample_o == $past(sample_i));

    p_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gain_i == '0 |=> sample_o == '0);
endmodule

// File: rtl/soft_mute_ramp.sv
// Ramped soft mute controller, stereo.
// Combines the external mute request with the semi-automatic start hold,
// drives one shared gain ramp and scales both channels with it.
// Assumes frame_stb pulses for one cycle per output frame and that
// RAMP_LEN is a power of two.
module soft_mute_ramp #(
    parameter  int DATA_W      = 24,
    parameter  int RAMP_LEN    = 1024,
    parameter  int HOLD_FRAMES = 4410,
    localparam int GAIN_W      = $clog2(RAMP_LEN) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_stb,
    input  logic                     mute_req,
    input  logic                     semi_auto,
    input  logic signed [DATA_W-1:0] in_left,
    input  logic signed [DATA_W-1:0] in_right,
    output logic signed [DATA_W-1:0] out_left,
    output logic signed [DATA_W-1:0] out_right,
    output logic        [GAIN_W-1:0] gain_level
);
    localparam int N_CH  = 2;
    localparam int SHIFT = $clog2(RAMP_LEN);

    logic                     hold_active;
    logic                     mute_eff;
    logic        [GAIN_W-1:0] gain;
    logic signed [DATA_W-1:0] ch_in  [N_CH];
    logic signed [DATA_W-1:0] ch_out [N_CH];

    smr_hold_timer #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .semi_req  (semi_auto),
        .hold_o    (hold_active)
    );

    // Mute is in force on request or during the start hold
    always_comb mute_eff = mute_req | hold_active;

    smr_gain_ramp #(.RAMP_LEN(RAMP_LEN)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .mute_i    (mute_eff),
        .semi_req  (semi_auto),
        .gain_o    (gain)
    );

    // Map the channel ports to arrays
    always_comb begin
        ch_in[0]  = in_left;
        ch_in[1]  = in_right;
        out_left  = ch_out[0];
        out_right = ch_out[1];
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        smr_scaler #(
            .DATA_W (DATA_W),
            .GAIN_W (GAIN_W),
            .SHIFT  (SHIFT)
        ) u_scale (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample_i (ch_in[c]),
            .gain_i   (gain),
            .sample_o (ch_out[c])
        );
    end

    always_comb gain_level = gain;

    p_hold_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> gain == '0);

    p_request_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mute_req |=> gain <= $past(gain));
endmodule

// File: tb/tb_soft_mute_ramp.sv
`timescale 1ns/1ps
module tb_soft_mute_ramp;
    localparam int DW   = 24;
    localparam int RAMP = 1024;
    localparam int HOLD = 4410;
    localparam int GW   = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_stb = 1'b0;
    logic mute_req = 1'b0;
    logic semi_auto = 1'b0;
    logic signed [DW-1:0] in_left = '0;
    logic signed [DW-1:0] in_right = '0;
    logic signed [DW-1:0] out_left, out_right;
    logic [GW-1:0] gain_level;

    int checks = 0;
    int errors = 0;
    int idx = 0;
    int exp_gain = RAMP;
    int exp_hold = 0;
    bit exp_semi = 1'b0;

    always #5 clk = ~clk;

    soft_mute_ramp dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mute_req(mute_req),
        .semi_auto(semi_auto), .in_left(in_left), .in_right(in_right),
        .out_left(out_left), .out_right(out_right), .gain_level(gain_level)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic signed [DW-1:0] pat(input int i);
        case (i % 6)
            0: return 24'sh7FFFFF;
            1: return 24'sh800000;
            2: return -24'sd1;
            3: return 24'sd1;
            default: return DW'(i * 32'h9E3779B1 + 32'h1234);
        endcase
    endfunction

    // Expected scaled value: product divided by 1024, truncated toward zero
    function automatic longint scale(input logic signed [DW-1:0] s, input int g);
        longint p = longint'(s) * g;
        if (p < 0) return -((-p) / RAMP);
        return p / RAMP;
    endfunction

    task automatic do_reset(input int n, input bit semi, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rst_n = 1'b0; semi_auto = semi; frame_stb = 1'b1;
            in_left = pat(idx); in_right = pat(idx + 3); idx++;
            @(posedge clk); #1;
            chk({tag, " R1 out_left zero in reset"}, out_left, 0);
            chk({tag, " R1 out_right zero in reset"}, out_right, 0);
            chk({tag, " R1 gain reset value"}, gain_level, semi ? 0 : RAMP);
        end
        exp_gain = semi ? 0 : RAMP;
        exp_hold = 0;
        exp_semi = semi;
        @(negedge clk);
        rst_n = 1'b1; frame_stb = 1'b0;
    endtask

    // One clock with the given strobe and request; checks gain and both outputs
    task automatic step(input bit stb, input bit mute, input string tag);
        logic signed [DW-1:0] sl, sr;
        int old_g;
        bit eff;
        @(negedge clk);
        frame_stb = stb; mute_req = mute;
        in_left = pat(idx); in_right = pat(idx + 3); idx++;
        sl = in_left; sr = in_right; old_g = exp_gain;
        @(posedge clk); #1;
        if (stb) begin
            eff = mute || (exp_semi && exp_hold < HOLD);
            if (exp_semi && exp_hold < HOLD) exp_hold++;
            if (eff && exp_gain > 0) exp_gain--;
            else if (!eff && exp_gain < RAMP) exp_gain++;
        end
        chk({tag, " gain"}, gain_level, exp_gain);
        chk("R6 out_left scaling", out_left, scale(sl, old_g));
        chk("R6 out_right scaling", out_right, scale(sr, old_g));
    endtask

    initial begin : watchdog
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        // Manual mode start
        do_reset(3, 1'b0, "manual");
        for (int k = 0; k < 20; k++) step(1'b0, 1'b0, "R5 no strobe");
        chk("R1 manual starts at unity", gain_level, RAMP);

        // Full descent with every gain value
        for (int k = 0; k < RAMP; k++) step(1'b1, 1'b1, "R2 descent");
        chk("R2 zero after 1024 strobes", gain_level, 0);
        for (int k = 0; k < 10; k++) step(1'b1, 1'b1, "R2 stays zero");

        // Full ascent
        for (int k = 0; k < RAMP; k++) step(1'b1, 1'b0, "R3 ascent");
        chk("R3 unity after 1024 strobes", gain_level, RAMP);
        for (int k = 0; k < 10; k++) step(1'b1, 1'b0, "R3 stays unity");

        // Cancel mid-descent, reverse from the current point
        for (int k = 0; k < 300; k++) step(1'b1, 1'b1, "R4 partial descent");
        chk("R4 partial value", gain_level, RAMP - 300);
        for (int k = 0; k < 299; k++) step(1'b1, 1'b0, "R4 reverse");
        chk("R4 one short of unity", gain_level, RAMP - 1);
        step(1'b1, 1'b0, "R4 reverse end");
        chk("R4 unity after equal strobes", gain_level, RAMP);

        // Sparse strobes: gain moves only on strobe cycles
        for (int k = 0; k < 90; k++) step(k % 3 == 0, 1'b1, "R5 sparse descent");
        chk("R5 thirty steps down", gain_level, RAMP - 30);
        for (int k = 0; k < 90; k++) step(k % 3 == 1, 1'b0, "R5 sparse ascent");

        // Mode change during operation is ignored
        @(negedge clk); semi_auto = 1'b1;
        for (int k = 0; k < 20; k++) step(1'b1, 1'b0, "R9 mode change ignored");
        chk("R9 gain still unity", gain_level, RAMP);

        // Reset in the middle of a ramp clears outputs
        for (int k = 0; k < 40; k++) step(1'b1, 1'b1, "R2 pre-reset descent");
        do_reset(2, 1'b1, "midramp");

        // Semi-automatic start, request low
        for (int k = 0; k < HOLD; k++) step(1'b1, 1'b0, "R7 hold");
        chk("R7 still zero after 4410 strobes", gain_level, 0);
        step(1'b1, 1'b0, "R7 release");
        chk("R7 one on strobe 4411", gain_level, 1);
        for (int k = 0; k < RAMP - 1; k++) step(1'b1, 1'b0, "R7 fade in");
        chk("R7 unity on strobe 5434", gain_level, RAMP);

        // Semi-automatic start, request high at release
        @(negedge clk); mute_req = 1'b1;
        do_reset(2, 1'b1, "semi-req");
        for (int k = 0; k < HOLD + 200; k++) step(1'b1, 1'b1, "R8 held");
        chk("R8 no release while request high", gain_level, 0);
        for (int k = 0; k < 30; k++) step(1'b0, 1'b0, "R8 drop without strobe");
        step(1'b1, 1'b0, "R8 first strobe after drop");
        chk("R8 fade starts", gain_level, 1);
        for (int k = 0; k < 50; k++) step(1'b1, 1'b0, "R3 ascent after hold");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule